// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block keeps a single Hamming code over an entire NAND page while the page streams past on the flash data bus, one bus word per strobed beat. Every data bit has a 16-bit index made of its word address (upper 12 bits) and its bit position in the word (lower 4 bits). Each set bit folds its index into a parity accumulator and the complement of its index into a second, complementary accumulator. On a program pass the host reads both accumulators once the data area has passed. It then stores them as four check bytes in the spare area.

On a read pass the host streams the page data and then, as the very next beats, the four stored check bytes. On the last check byte the engine XORs computed and stored codes into a 32-bit syndrome and classifies it. The result is one of four cases: a clean page, one flipped data bit at a reported location, one flipped bit inside the check bytes, or damage beyond repair. Fixing the buffer is left to the host. The page size is picked by a mode field, and the engine counts data and spare beats so that extra beats do not disturb a finished result.

Top module: `nand_ecc_engine`

## Requirements
- R1: After reset the mode, status, parity and complementary parity registers all read zero.
- R2: During the data beats the parity register (address 3) reads the XOR of the indices of all set data bits, and the complementary register (address 4) reads the XOR of their 16-bit complemented indices. An index is {word address[11:0], bit number[3:0]}.
- R3: The mode register (address 1, bits [1:0]) selects a page of 528, 1056, 2112 or 4224 bytes for codes 0 to 3. Of these, 512, 1024, 2048 or 4096 bytes are data, covered by one code.
- R4: The check beats directly follow the data. In byte order they are parity low, parity high, complementary low, complementary high; a 16-bit bus carries parity then complementary.
- R5: When the syndrome is zero, the status register (address 2) reads 4'b1000 and the parity register reads zero. Status bits are [0] error seen, [1] check-byte error, [2] multiple error, [3] check complete.
- R6: A single flipped data bit gives status 4'b1001, and the parity register then reads {word address, bit number} of that bit.
- R7: A single flipped bit inside the four check bytes gives status 4'b1011.
- R8: Two flipped data bits give status 4'b1101.
- R9: A page whose data and check bytes are all 0xFF gives status 4'b1101 and a parity register of 16'hFFFF.
- R10: The check-complete bit stays clear until the beat that carries the last check byte has been taken.
- R11: Beats after the check bytes, including beats past the configured page size, change neither status nor either register.
- R12: Writing 1 to bit 0 of the control register (address 0), or writing the mode register, clears the beat count, both accumulators, the captured code and the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 mode, 2 status, 3 parity, 4 complementary parity |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for the address seen at the previous clock edge |
| beat_valid | input | 1 | A bus word is present on beat_data this cycle |
| beat_data | input | DATA_W | Flash bus word (8 or 16 bits) |

## Verification
The assertions check on every cycle that the error flags stay consistent: a check-byte or multiple error always carries the error-seen bit, and the two never appear together. They also check that completion appears only on a beat, that a finished result and its accumulators stay frozen, and that a clear command empties the state. The bench alone can show that the syndrome classes land on the right flipped bits and that the reported location matches the flipped word and bit. It also covers the mode-dependent page lengths, the order of the check bytes and the erased-page signature. To do so it compares every register read against a behavioural model as full pages stream.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int WADDR_W        = 12;
  localparam int BIT_W          = 4;
  localparam int IDX_W          = WADDR_W + BIT_W;
  localparam int CODE_W         = 2 * IDX_W;
  localparam int CODE_BYTES     = CODE_W / 8;
  localparam int CNT_W          = 14;
  localparam int REG_AW         = 3;
  localparam int REG_DW         = 16;
  localparam int DATA_BYTES_MIN = 512;
  localparam int PAGE_BYTES_MIN = 528;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_MODE = 3'd1;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd2;
  localparam logic [REG_AW-1:0] RA_PAR  = 3'd3;
  localparam logic [REG_AW-1:0] RA_NPAR = 3'd4;

  typedef struct packed {
    logic done;
    logic mul;
    logic ecc;
    logic recov;
  } ecc_stat_t;
endpackage

// File: rtl/nand_ecc_beat_par.sv
module nand_ecc_beat_par
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [WADDR_W-1:0] word_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [IDX_W-1:0]   p_o,
  output logic [IDX_W-1:0]   np_o
);
  logic [BIT_W-1:0] bx;
  logic [BIT_W-1:0] nbx;
  logic             odd;

  always_comb begin
    bx  = '0;
    nbx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (data_i[i]) begin
        bx  = bx ^ BIT_W'(i);
        nbx = nbx ^ ~BIT_W'(i);
      end
    end
    odd  = ^data_i;
    p_o  = {word_i & {WADDR_W{odd}}, bx};
    np_o = {~word_i & {WADDR_W{odd}}, nbx};
  end
endmodule

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BPB        = DATA_W / 8,
  localparam int CODE_BEATS = CODE_BYTES / BPB,
  localparam int SLOT_W     = (CODE_BEATS > 1) ? $clog2(CODE_BEATS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               beat_i,
  input  logic [1:0]         mode_i,
  output logic [WADDR_W-1:0] word_o,
  output logic               data_ph_o,
  output logic               code_ph_o,
  output logic [SLOT_W-1:0]  code_slot_o,
  output logic               code_last_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int BASE_DATA  = DATA_BYTES_MIN / BPB;
  localparam int BASE_TOTAL = PAGE_BYTES_MIN / BPB;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] data_lim;
  logic [CNT_W-1:0] code_lim;
  logic [CNT_W-1:0] total_lim;
  logic [CNT_W-1:0] code_off;

  always_comb begin
    data_lim    = CNT_W'(BASE_DATA) << mode_i;
    total_lim   = CNT_W'(BASE_TOTAL) << mode_i;
    code_lim    = data_lim + CNT_W'(CODE_BEATS);
    code_off    = cnt_q - data_lim;
    data_ph_o   = cnt_q < data_lim;
    code_ph_o   = (cnt_q >= data_lim) && (cnt_q < code_lim);
    code_slot_o = code_off[SLOT_W-1:0];
    code_last_o = code_ph_o && (code_slot_o == SLOT_W'(CODE_BEATS - 1));
    word_o      = cnt_q[WADDR_W-1:0];
    cnt_o       = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (beat_i && (cnt_q < total_lim)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify
  import nand_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] syn_i,
  output logic              recov_o,
  output logic              ecc_o,
  output logic              mul_o
);
  logic [IDX_W-1:0] sp;
  logic [IDX_W-1:0] sn;
  logic             zero;
  logic             one_hot;
  logic             mirrored;

  always_comb begin
    sp       = syn_i[IDX_W-1:0];
    sn       = syn_i[CODE_W-1:IDX_W];
    zero     = (syn_i == '0);
    one_hot  = $onehot(syn_i);
    mirrored = (sp == ~sn);
    recov_o  = !zero;
    ecc_o    = one_hot;
    mul_o    = !zero && !one_hot && !mirrored;
  end
endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data
);
  localparam int BPB        = DATA_W / 8;
  localparam int CODE_BEATS = CODE_BYTES / BPB;
  localparam int SLOT_W     = (CODE_BEATS > 1) ? $clog2(CODE_BEATS) : 1;

  logic [1:0]         mode_q;
  logic [IDX_W-1:0]   p_acc;
  logic [IDX_W-1:0]   np_acc;
  logic [IDX_W-1:0]   loc_q;
  logic [CODE_W-1:0]  code_q;
  logic [CODE_W-1:0]  code_now;
  logic [CODE_W-1:0]  syn;
  ecc_stat_t          stat_q;
  logic               clr;
  logic [WADDR_W-1:0] word;
  logic               data_ph;
  logic               code_ph;
  logic [SLOT_W-1:0]  slot;
  logic               code_last;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   p_c;
  logic [IDX_W-1:0]   np_c;
  logic               c_recov;
  logic               c_ecc;
  logic               c_mul;

  assign clr = reg_wr && (((reg_addr == RA_CTRL) && reg_wdata[0]) || (reg_addr == RA_MODE));

  nand_ecc_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .beat_i     (beat_valid),
    .mode_i     (mode_q),
    .word_o     (word),
    .data_ph_o  (data_ph),
    .code_ph_o  (code_ph),
    .code_slot_o(slot),
    .code_last_o(code_last),
    .cnt_o      (cnt)
  );

  nand_ecc_beat_par #(.DATA_W(DATA_W)) u_par (
    .word_i(word),
    .data_i(beat_data),
    .p_o   (p_c),
    .np_o  (np_c)
  );

  for (genvar s = 0; s < CODE_BEATS; s++) begin : g_slot
    assign code_now[s*DATA_W +: DATA_W] =
      (code_ph && (slot == SLOT_W'(s))) ? beat_data : code_q[s*DATA_W +: DATA_W];
  end

  assign syn = {np_acc, p_acc} ^ code_now;

  nand_ecc_classify u_cls (
    .syn_i  (syn),
    .recov_o(c_recov),
    .ecc_o  (c_ecc),
    .mul_o  (c_mul)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (reg_wr && (reg_addr == RA_MODE)) begin
      mode_q <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      p_acc  <= '0;
      np_acc <= '0;
      code_q <= '0;
      stat_q <= '0;
      loc_q  <= '0;
    end else if (beat_valid) begin
      if (data_ph) begin
        p_acc  <= p_acc ^ p_c;
        np_acc <= np_acc ^ np_c;
      end
      if (code_ph) begin
        code_q <= code_now;
      end
      if (code_last) begin
        stat_q <= '{done: 1'b1, mul: c_mul, ecc: c_ecc, recov: c_recov};
        loc_q  <= syn[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_MODE: reg_rdata <= {{(REG_DW-2){1'b0}}, mode_q};
        RA_STAT: reg_rdata <= {{(REG_DW-4){1'b0}}, stat_q};
        RA_PAR:  reg_rdata <= stat_q.done ? loc_q : p_acc;
        RA_NPAR: reg_rdata <= np_acc;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/nand_ecc_engine_chk.sv
module nand_ecc_engine_chk
  import nand_ecc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic              beat_valid,
  input logic [IDX_W-1:0]  p_acc,
  input logic [IDX_W-1:0]  np_acc,
  input logic [3:0]        stat,
  input logic [CNT_W-1:0]  beat_cnt
);
  logic clr_cmd;
  assign clr_cmd = reg_wr && ((reg_addr == 3'd1) || ((reg_addr == 3'd0) && reg_wdata[0]));

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (p_acc == '0 && np_acc == '0 && stat == 4'b0000 && beat_cnt == '0));

  // R6 / R7 / R8
  a_r8_flags_consistent: assert property (@(posedge clk) disable iff (rst)
    (stat[1] || stat[2]) |-> (stat[0] && !(stat[1] && stat[2])));

  // R10
  a_r10_done_on_beat: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[3]) |-> $past(beat_valid));

  // R11
  a_r11_frozen_after_done: assert property (@(posedge clk) disable iff (rst)
    (stat[3] && !clr_cmd) |=> ($stable(p_acc) && $stable(np_acc) && $stable(stat)));

  // R12
  a_r12_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (p_acc == '0 && np_acc == '0 && stat == 4'b0000 && beat_cnt == '0));
endmodule

bind nand_ecc_engine nand_ecc_engine_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .beat_valid(beat_valid),
  .p_acc     (p_acc),
  .np_acc    (np_acc),
  .stat      (stat_q),
  .beat_cnt  (cnt)
);

// File: tb/test_nand_ecc_engine.sv
module test_nand_ecc_engine;
  localparam int DW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        beat_valid = 1'b0;
  logic [DW-1:0] beat_data = '0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nand_ecc_engine #(.DATA_W(DW)) i_nand_ecc_engine (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .beat_valid(beat_valid),
    .beat_data (beat_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural syndrome classification: returns {status, location}
  function automatic logic [19:0] classify(input logic [15:0] p, input logic [15:0] np,
                                            input logic [31:0] code);
    logic [15:0] sp;
    logic [15:0] sn;
    int ones;
    logic [3:0] st;
    sp = p ^ code[15:0];
    sn = np ^ code[31:16];
    ones = 0;
    for (int i = 0; i < 16; i++) ones += int'(sp[i]) + int'(sn[i]);
    if (ones == 0) st = 4'b1000;
    else if (ones == 1) st = 4'b1011;
    else if (sp == ~sn) st = 4'b1001;
    else st = 4'b1101;
    return {st, sp};
  endfunction

  // ---------------- cycle-by-cycle reference model ----------------
  int          m_mode;
  int          m_cnt;
  logic [15:0] m_p, m_np, m_loc;
  logic [31:0] m_code;
  logic [3:0]  m_stat;
  logic [15:0] exp_rd;
  logic [2:0]  exp_addr;
  bit          exp_on = 1'b0;

  task automatic model_clear();
    m_cnt = 0; m_p = '0; m_np = '0; m_loc = '0; m_code = '0; m_stat = '0;
  endtask

  task automatic model_beat(input logic [DW-1:0] d);
    int nd, total, nc, idx;
    logic [19:0] r;
    nd    = ((512 << m_mode) * 8) / DW;
    total = ((528 << m_mode) * 8) / DW;
    nc    = 32 / DW;
    if (m_cnt < nd) begin
      for (int i = 0; i < DW; i++) begin
        if (d[i]) begin
          idx  = m_cnt * 16 + i;
          m_p  = m_p ^ idx[15:0];
          m_np = m_np ^ ~idx[15:0];
        end
      end
    end else if (m_cnt < nd + nc) begin
      m_code[(m_cnt - nd) * DW +: DW] = d;
      if (m_cnt == nd + nc - 1) begin
        r = classify(m_p, m_np, m_code);
        m_stat = r[19:16];
        m_loc  = r[15:0];
      end
    end
    if (m_cnt < total) m_cnt++;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0;
      model_clear();
      exp_rd = '0;
      exp_addr = 3'd0;
      exp_on = 1'b1;
    end else begin
      exp_addr = reg_addr;
      case (reg_addr)
        3'd1: exp_rd = 16'(m_mode);
        3'd2: exp_rd = {12'd0, m_stat};
        3'd3: exp_rd = m_stat[3] ? m_loc : m_p;
        3'd4: exp_rd = m_np;
        default: exp_rd = '0;
      endcase
      if (reg_wr && (reg_addr == 3'd1 || (reg_addr == 3'd0 && reg_wdata[0]))) begin
        model_clear();
        if (reg_addr == 3'd1) m_mode = int'(reg_wdata[1:0]);
      end else if (beat_valid) begin
        model_beat(beat_data);
      end
    end
  end

  always @(negedge clk) begin
    if (exp_on && !finished) begin
      case (exp_addr)
        3'd1:       check("R3 per-cycle mode read", reg_rdata, exp_rd);
        3'd2:       check("R6 per-cycle status read", reg_rdata, exp_rd);
        3'd3, 3'd4: check("R2 per-cycle parity read", reg_rdata, exp_rd);
        default:    check("R12 per-cycle control read", reg_rdata, exp_rd);
      endcase
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [7:0] pat(input int b);
    return 8'((b * 37 + 11) ^ (b >> 3));
  endfunction

  function automatic logic [31:0] calc(input int mode);
    logic [15:0] p, np;
    logic [7:0] d;
    int nd, idx;
    p = '0; np = '0;
    nd = 512 << mode;
    for (int w = 0; w < nd; w++) begin
      d = pat(w);
      for (int i = 0; i < 8; i++) begin
        if (d[i]) begin
          idx = w * 16 + i;
          p  = p ^ idx[15:0];
          np = np ^ ~idx[15:0];
        end
      end
    end
    return {np, p};
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v; beat_valid = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; beat_valid = 1'b0;
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  task automatic send(input int mode, input int from, input int upto, input bit erased,
                      input int fw1, input int fb1, input int fw2, input int fb2,
                      input logic [31:0] code);
    int nd;
    logic [7:0] d;
    nd = 512 << mode;
    for (int b = from; b < upto; b++) begin
      if (erased) d = 8'hFF;
      else if (b < nd) begin
        d = pat(b);
        if (b == fw1) d = d ^ (8'd1 << fb1);
        if (b == fw2) d = d ^ (8'd1 << fb2);
      end else if (b < nd + 4) d = code[(b - nd) * 8 +: 8];
      else d = 8'hA5;
      @(negedge clk);
      beat_valid = 1'b1; beat_data = d;
    end
    @(negedge clk);
    beat_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  // ---------------- scenarios ----------------
  logic [31:0] c0, c1, swapped;
  logic [19:0] r_sw;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    reg_read(3'd2, 16'h0000, "R1 status after reset");
    reg_read(3'd3, 16'h0000, "R1 parity after reset");
    reg_read(3'd4, 16'h0000, "R1 complementary parity after reset");
    reg_read(3'd1, 16'h0000, "R1 mode after reset");

    c0 = calc(0);
    c1 = calc(1);

    // program pass, 528-byte page
    reg_write(3'd1, 16'd0);
    send(0, 0, 512, 1'b0, -1, 0, -1, 0, c0);
    reg_read(3'd3, c0[15:0], "R2 parity after data beats");
    reg_read(3'd4, c0[31:16], "R2 complementary parity after data beats");
    reg_read(3'd2, 16'h0000, "R10 no completion before check bytes");

    // clean read pass in pieces
    reg_write(3'd0, 16'd1);
    send(0, 0, 515, 1'b0, -1, 0, -1, 0, c0);
    reg_read(3'd2, 16'h0000, "R10 no completion after three check bytes");
    send(0, 515, 516, 1'b0, -1, 0, -1, 0, c0);
    reg_read(3'd2, 16'h0008, "R5 clean page status");
    reg_read(3'd3, 16'h0000, "R5 clean page location");
    send(0, 516, 534, 1'b0, -1, 0, -1, 0, c0);
    reg_read(3'd2, 16'h0008, "R11 status after spare and excess beats");
    reg_read(3'd3, 16'h0000, "R11 location after excess beats");
    reg_read(3'd4, c0[31:16], "R11 complementary parity after excess beats");

    // check bytes in swapped order must not read as clean
    swapped = {c0[15:0], c0[31:16]};
    r_sw = classify(c0[15:0], c0[31:16], swapped);
    reg_write(3'd0, 16'd1);
    send(0, 0, 528, 1'b0, -1, 0, -1, 0, swapped);
    reg_read(3'd2, {12'd0, r_sw[19:16]}, "R4 swapped check bytes detected");

    // single data error
    reg_write(3'd0, 16'd1);
    send(0, 0, 528, 1'b0, 37, 5, -1, 0, c0);
    reg_read(3'd2, 16'h0009, "R6 single data error status");
    reg_read(3'd3, {12'd37, 4'd5}, "R6 single data error location");

    // error in a check byte
    reg_write(3'd0, 16'd1);
    send(0, 0, 528, 1'b0, -1, 0, -1, 0, c0 ^ 32'h0800_0000);
    reg_read(3'd2, 16'h000B, "R7 check byte error status");

    // two data errors
    reg_write(3'd0, 16'd1);
    send(0, 0, 528, 1'b0, 37, 5, 200, 0, c0);
    reg_read(3'd2, 16'h000D, "R8 double error status");

    // 1056-byte page, error beyond the first 512 bytes
    reg_write(3'd1, 16'd1);
    reg_read(3'd1, 16'h0001, "R3 mode readback");
    send(1, 0, 1056, 1'b0, 1000, 6, -1, 0, c1);
    reg_read(3'd2, 16'h0009, "R3 larger page single error status");
    reg_read(3'd3, {12'd1000, 4'd6}, "R3 larger page error location");

    // clear mid-page by command and by mode write
    reg_write(3'd0, 16'd1);
    send(1, 0, 100, 1'b0, -1, 0, -1, 0, c1);
    reg_write(3'd0, 16'd1);
    reg_read(3'd3, 16'h0000, "R12 parity cleared by command");
    reg_read(3'd4, 16'h0000, "R12 complementary parity cleared by command");
    send(1, 0, 50, 1'b0, -1, 0, -1, 0, c1);
    reg_write(3'd1, 16'd3);
    reg_read(3'd3, 16'h0000, "R12 parity cleared by mode write");
    reg_read(3'd2, 16'h0000, "R12 status cleared by mode write");

    // erased 4224-byte page
    send(3, 0, 4224, 1'b1, -1, 0, -1, 0, 32'hFFFF_FFFF);
    reg_read(3'd2, 16'h000D, "R9 erased page status");
    reg_read(3'd3, 16'hFFFF, "R9 erased page location");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule